// File: doc/BRIEF.md
# SPI FIFO Status, Interrupt and DMA Request Controller

This block is the bookkeeping side of a SPI controller's transmit and receive FIFOs. It does not hold FIFO data and does not shift bits. Instead it counts the entries in each FIFO from push and pop strobes. It compares those counts against thresholds written through a small write port. From these it produces a status word, a raw interrupt vector, a masked interrupt vector, one combined interrupt line and two DMA request lines. Overflow and underflow events are kept as sticky error flags until a write to the clear register removes them.

A single enable input gates the whole block. Dropping enable flushes both level counts to zero on the next clock edge. While enable is high, the four threshold registers are locked and writes to them have no effect. The interrupt thresholds fire on strict crossings: a threshold register value of N means the receive-full interrupt appears once N+1 entries are held. A three-state machine drives the busy status bit. Its states are OFF, IDLE and RUN, with these transitions:
- OFF goes to IDLE when enable rises.
- IDLE goes to RUN when the TX FIFO holds data or the serial engine reports busy.
- RUN goes back to IDLE when neither holds.
- IDLE and RUN both go to OFF whenever enable is low.

The FIFO depth is a parameter, either 32 or 64.

Top module: `spi_fifo_status_ctrl`

## Requirements
- R1: After reset both levels are 0, all sticky flags are clear, the mask is 0, `irq` is 0, both DMA requests are 0 and `status` is 5'b01100.
- R2: Each level changes at the clock edge after its strobes. A push is accepted when the FIFO is not full, and a pop is accepted when it is not empty. When both are accepted in the same cycle, the level is unchanged.
- R3: A push into a full FIFO is dropped and the level is unchanged. For TX this sets sticky flag `raw_irq[1]`, and for RX it sets sticky flag `raw_irq[3]`.
- R4: A pop from an empty RX FIFO leaves the level at 0 and sets sticky flag `raw_irq[2]`.
- R5: A write to address 3 clears flags. Bit 0 clears all three flags, bit 1 clears RX underflow, bit 2 clears RX overflow and bit 3 clears TX overflow. If a flag is set and cleared in the same cycle, the set wins.
- R6: `raw_irq[4]` is 1 when the RX level is greater than the RX threshold (address 1). `raw_irq[0]` is 1 when the TX level is at most the TX threshold (address 0).
- R7: The `status` bits are: bit 1 TX full (level equals DEPTH), bit 2 TX empty, bit 3 RX empty, bit 4 RX full.
- R8: `status[0]` (busy) is 1 only in state RUN. The state register moves along OFF, IDLE and RUN as described above, and the busy bit changes one edge after its cause.
- R9: The mask is written at address 2. `masked_irq` equals `raw_irq & mask`, and `irq` is the OR of `masked_irq`.
- R10: The DMA enable register is at address 4, with bit 0 for RX and bit 1 for TX. `tx_dma_req` is 1 when enable is high, the TX bit is set and the TX level is at most the TX DMA level (address 5). `rx_dma_req` is 1 when enable is high, the RX bit is set and the RX level is at least the RX DMA level (address 6) plus one.
- R11: With enable low, both levels become 0 at the next edge. Strobes seen while disabled are ignored and set no flag.
- R12: Writes to addresses 0, 1, 5 and 6 are ignored while enable is high. Writes to addresses 2, 3 and 4 take effect at any time, and address 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low flushes levels |
| engine_busy | input | 1 | Serial engine is shifting |
| tx_push | input | 1 | Word written into TX FIFO |
| tx_pop | input | 1 | Word taken from TX FIFO by the engine |
| rx_push | input | 1 | Word written into RX FIFO by the engine |
| rx_pop | input | 1 | Word read from RX FIFO |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | WD = max(log2(DEPTH),5) | Register write data |
| tx_level | output | log2(DEPTH)+1 | TX FIFO entry count |
| rx_level | output | log2(DEPTH)+1 | RX FIFO entry count |
| status | output | 5 | Busy and full/empty flags |
| raw_irq | output | 5 | Unmasked interrupt sources |
| masked_irq | output | 5 | Interrupt sources after mask |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The bench sweeps every RX and TX threshold value and every DMA level. It fills each FIFO one entry past full at each setting. This catches an off-by-one in the strict comparison, which would fire the RX-full interrupt or RX DMA request one entry early or late, and a level counter that wraps past DEPTH instead of flagging overflow. It also targets a clear that is applied in the same cycle as a new error and wrongly wins, a single clear bit that wipes its neighbours, a threshold write that slips through while enabled, and a busy bit that skips the IDLE state after enable rises. A long pseudo-random phase mixes simultaneous push and pop, enable toggling and arbitrary writes against an arithmetic model.

// File: rtl/spi_fsr_pkg.sv
`timescale 1ns/1ps
package spi_fsr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } run_state_t;

    // status word bit positions
    localparam int SB_BUSY    = 0;
    localparam int SB_TX_FULL = 1;
    localparam int SB_TX_EMPT = 2;
    localparam int SB_RX_EMPT = 3;
    localparam int SB_RX_FULL = 4;

    // interrupt vector bit positions
    localparam int IB_TX_LOW  = 0;
    localparam int IB_TX_OVF  = 1;
    localparam int IB_RX_UNF  = 2;
    localparam int IB_RX_OVF  = 3;
    localparam int IB_RX_HIGH = 4;

    // clear register bit positions
    localparam int CB_ALL    = 0;
    localparam int CB_RX_UNF = 1;
    localparam int CB_RX_OVF = 2;
    localparam int CB_TX_OVF = 3;

    // register addresses
    localparam logic [2:0] ADR_TX_THR  = 3'd0;
    localparam logic [2:0] ADR_RX_THR  = 3'd1;
    localparam logic [2:0] ADR_MASK    = 3'd2;
    localparam logic [2:0] ADR_CLEAR   = 3'd3;
    localparam logic [2:0] ADR_DMA_EN  = 3'd4;
    localparam logic [2:0] ADR_TXD_LVL = 3'd5;
    localparam logic [2:0] ADR_RXD_LVL = 3'd6;

endpackage

// File: rtl/fifo_level_track.sv
`timescale 1ns/1ps
module fifo_level_track #(
    parameter int DEPTH = 32,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic          pop,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic take_in;
    logic take_out;

    always_comb begin
        full     = (level == LW'(DEPTH));
        empty    = (level == '0);
        take_in  = push && !full;
        take_out = pop && !empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (!en) begin
            level <= '0;
        end else begin
            level <= level + LW'(take_in) - LW'(take_out);
        end
    end

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (level == $past(level)) || (level == $past(level) + LW'(1))
               || (level == $past(level) - LW'(1)));

    a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> level == '0);

    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        en && push && !pop && full |=> full);

    a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        en && pop && !push && empty |=> empty);

endmodule

// File: rtl/fifo_cfg_regs.sv
`timescale 1ns/1ps
module fifo_cfg_regs import spi_fsr_pkg::*; #(
    parameter int AW = 5,
    localparam int WD = (AW > 5) ? AW : 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [WD-1:0] wr_data,
    output logic [AW-1:0] tx_thr,
    output logic [AW-1:0] rx_thr,
    output logic [AW-1:0] txd_lvl,
    output logic [AW-1:0] rxd_lvl,
    output logic [4:0]    mask,
    output logic [1:0]    dma_en,
    output logic [3:0]    clr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr  <= '0;
            rx_thr  <= '0;
            txd_lvl <= '0;
            rxd_lvl <= '0;
            mask    <= '0;
            dma_en  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_TX_THR:  if (!enable) tx_thr  <= wr_data[AW-1:0];
                ADR_RX_THR:  if (!enable) rx_thr  <= wr_data[AW-1:0];
                ADR_TXD_LVL: if (!enable) txd_lvl <= wr_data[AW-1:0];
                ADR_RXD_LVL: if (!enable) rxd_lvl <= wr_data[AW-1:0];
                ADR_MASK:    mask   <= wr_data[4:0];
                ADR_DMA_EN:  dma_en <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        clr = (wr_en && wr_addr == ADR_CLEAR) ? wr_data[3:0] : 4'b0000;
    end

    a_r12_rx_thr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(rx_thr));

    a_r12_tx_thr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(tx_thr) && $stable(txd_lvl) && $stable(rxd_lvl));

endmodule

// File: rtl/spi_fifo_status_ctrl.sv
`timescale 1ns/1ps
module spi_fifo_status_ctrl import spi_fsr_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1,
    localparam int WD = (AW > 5) ? AW : 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          engine_busy,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [WD-1:0] wr_data,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic [4:0]    status,
    output logic [4:0]    raw_irq,
    output logic [4:0]    masked_irq,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req
);

    generate
        if (DEPTH != 32 && DEPTH != 64) begin : g_bad_depth
            $error("DEPTH must be 32 or 64");
        end
    endgenerate

    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [AW-1:0] tx_thr, rx_thr, txd_lvl, rxd_lvl;
    logic [4:0]    mask;
    logic [1:0]    dma_en;
    logic [3:0]    clr;

    fifo_cfg_regs #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .txd_lvl(txd_lvl), .rxd_lvl(rxd_lvl),
        .mask(mask), .dma_en(dma_en), .clr(clr)
    );

    fifo_level_track #(.DEPTH(DEPTH)) u_tx_lvl (
        .clk(clk), .rst_n(rst_n), .en(enable), .push(tx_push), .pop(tx_pop),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    fifo_level_track #(.DEPTH(DEPTH)) u_rx_lvl (
        .clk(clk), .rst_n(rst_n), .en(enable), .push(rx_push), .pop(rx_pop),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    // error events and sticky flags
    logic ev_tx_ovf, ev_rx_ovf, ev_rx_unf;
    logic tx_ovf_q, rx_ovf_q, rx_unf_q;

    always_comb begin
        ev_tx_ovf = enable && tx_push && tx_full;
        ev_rx_ovf = enable && rx_push && rx_full;
        ev_rx_unf = enable && rx_pop && rx_empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
            rx_unf_q <= 1'b0;
        end else begin
            tx_ovf_q <= (tx_ovf_q && !(clr[CB_ALL] || clr[CB_TX_OVF])) || ev_tx_ovf;
            rx_ovf_q <= (rx_ovf_q && !(clr[CB_ALL] || clr[CB_RX_OVF])) || ev_rx_ovf;
            rx_unf_q <= (rx_unf_q && !(clr[CB_ALL] || clr[CB_RX_UNF])) || ev_rx_unf;
        end
    end

    // busy state machine
    run_state_t state_q, state_d;
    logic       work;

    always_comb begin
        work    = !tx_empty || engine_busy;
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_d = ST_IDLE;
            ST_IDLE: begin
                if (!enable)   state_d = ST_OFF;
                else if (work) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!enable)    state_d = ST_OFF;
                else if (!work) state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        status             = '0;
        status[SB_BUSY]    = (state_q == ST_RUN);
        status[SB_TX_FULL] = tx_full;
        status[SB_TX_EMPT] = tx_empty;
        status[SB_RX_EMPT] = rx_empty;
        status[SB_RX_FULL] = rx_full;

        raw_irq             = '0;
        raw_irq[IB_TX_LOW]  = (tx_level <= {1'b0, tx_thr});
        raw_irq[IB_TX_OVF]  = tx_ovf_q;
        raw_irq[IB_RX_UNF]  = rx_unf_q;
        raw_irq[IB_RX_OVF]  = rx_ovf_q;
        raw_irq[IB_RX_HIGH] = (rx_level > {1'b0, rx_thr});

        masked_irq = raw_irq & mask;
        irq        = |masked_irq;

        tx_dma_req = enable && dma_en[1] && (tx_level <= {1'b0, txd_lvl});
        rx_dma_req = enable && dma_en[0] && (rx_level >= ({1'b0, rxd_lvl} + LW'(1)));
    end

    a_r3_tx_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enable && tx_push && tx_full |=> raw_irq[IB_TX_OVF]);

    a_r3_rx_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enable && rx_push && rx_full |=> raw_irq[IB_RX_OVF]);

    a_r4_rx_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enable && rx_pop && rx_empty |=> raw_irq[IB_RX_UNF]);

    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADR_CLEAR && wr_data[CB_ALL]
        && !ev_tx_ovf && !ev_rx_ovf && !ev_rx_unf |=> raw_irq[3:1] == 3'b000);

    a_r8_busy_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !status[SB_BUSY]);

    a_r11_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !raw_irq[IB_TX_OVF] && !wr_en |=> !raw_irq[IB_TX_OVF]);

endmodule

// File: tb/spi_fifo_status_ctrl_bench.sv
`timescale 1ns/1ps
module spi_fifo_status_ctrl_bench;

    localparam int D  = 32;
    localparam int LW = 6;
    localparam int WD = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          enable = 1'b0, engine_busy = 1'b0;
    logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [WD-1:0] wr_data = '0;
    logic [LW-1:0] tx_level, rx_level;
    logic [4:0]    status, raw_irq, masked_irq;
    logic          irq, tx_dma_req, rx_dma_req;

    spi_fifo_status_ctrl #(.DEPTH(D)) u_spi_fifo_status_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .engine_busy(engine_busy),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_level(tx_level), .rx_level(rx_level), .status(status),
        .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int m_tx, m_rx, m_st;
    bit m_txo, m_rxo, m_rxu;
    int m_txthr, m_rxthr, m_txd, m_rxd, m_mask, m_dma;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_tx = 0; m_rx = 0; m_st = 0;
        m_txo = 0; m_rxo = 0; m_rxu = 0;
        m_txthr = 0; m_rxthr = 0; m_txd = 0; m_rxd = 0; m_mask = 0; m_dma = 0;
    endtask

    task automatic model_edge();
        bit [3:0] c;
        bit s_txo, s_rxo, s_rxu;
        c = (wr_en && wr_addr == 3'd3) ? wr_data[3:0] : 4'b0;
        s_txo = enable && tx_push && (m_tx == D);
        s_rxo = enable && rx_push && (m_rx == D);
        s_rxu = enable && rx_pop && (m_rx == 0);
        if (c[0] || c[3]) m_txo = 0;
        if (c[0] || c[2]) m_rxo = 0;
        if (c[0] || c[1]) m_rxu = 0;
        m_txo = m_txo | s_txo;
        m_rxo = m_rxo | s_rxo;
        m_rxu = m_rxu | s_rxu;
        if (wr_en) begin
            case (wr_addr)
                3'd0: if (!enable) m_txthr = int'(wr_data);
                3'd1: if (!enable) m_rxthr = int'(wr_data);
                3'd5: if (!enable) m_txd = int'(wr_data);
                3'd6: if (!enable) m_rxd = int'(wr_data);
                3'd2: m_mask = int'(wr_data);
                3'd4: m_dma = int'(wr_data) & 3;
                default: ;
            endcase
        end
        if (!enable) m_st = 0;
        else if (m_st == 0) m_st = 1;
        else m_st = (m_tx != 0 || engine_busy) ? 2 : 1;
        if (!enable) begin
            m_tx = 0; m_rx = 0;
        end else begin
            m_tx = m_tx + ((tx_push && m_tx < D) ? 1 : 0) - ((tx_pop && m_tx > 0) ? 1 : 0);
            m_rx = m_rx + ((rx_push && m_rx < D) ? 1 : 0) - ((rx_pop && m_rx > 0) ? 1 : 0);
        end
    endtask

    task automatic compare();
        int er;
        er = ((m_rx > m_rxthr) ? 16 : 0) | (m_rxo ? 8 : 0) | (m_rxu ? 4 : 0)
           | (m_txo ? 2 : 0) | ((m_tx <= m_txthr) ? 1 : 0);
        chk("R2 tx level", int'(tx_level), m_tx);
        chk("R2 rx level", int'(rx_level), m_rx);
        chk("R7 status flags", int'(status[4:1]),
            ((m_rx == D) ? 8 : 0) | ((m_rx == 0) ? 4 : 0) | ((m_tx == 0) ? 2 : 0) | ((m_tx == D) ? 1 : 0));
        chk("R8 busy", int'(status[0]), (m_st == 2) ? 1 : 0);
        chk("R6 thresholds", int'({raw_irq[4], raw_irq[0]}), ((er >> 3) & 2) | (er & 1));
        chk("R3 tx overflow", int'(raw_irq[1]), (er >> 1) & 1);
        chk("R3 rx overflow", int'(raw_irq[3]), (er >> 3) & 1);
        chk("R4 rx underflow", int'(raw_irq[2]), (er >> 2) & 1);
        chk("R9 masked", int'(masked_irq), er & m_mask);
        chk("R9 irq", int'(irq), ((er & m_mask) != 0) ? 1 : 0);
        chk("R10 tx dma", int'(tx_dma_req), (enable && m_dma[1] && m_tx <= m_txd) ? 1 : 0);
        chk("R10 rx dma", int'(rx_dma_req), (enable && m_dma[0] && m_rx >= m_rxd + 1) ? 1 : 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #2;
        compare();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; wr_en = 0;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 3'(a); wr_data = WD'(d);
        tick();
    endtask

    task automatic set_all_flags();
        rx_pop = 1; tick();
        for (int i = 0; i <= D; i++) begin tx_push = 1; rx_push = 1; tick(); end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 tx level", int'(tx_level), 0);
        chk("R1 rx level", int'(rx_level), 0);
        chk("R1 status", int'(status), 5'b01100);
        chk("R1 irq", int'(irq), 0);
        chk("R1 flags", int'(raw_irq[3:1]), 0);
        chk("R1 dma", int'({tx_dma_req, rx_dma_req}), 0);
        compare();

        // R8 busy walks OFF -> IDLE -> RUN
        engine_busy = 1; enable = 1; tick();
        chk("R8 idle after enable", int'(status[0]), 0);
        tick();
        chk("R8 run after idle", int'(status[0]), 1);
        engine_busy = 0; tick();
        chk("R8 back to idle", int'(status[0]), 0);
        enable = 0; tick();

        // R6/R10 sweep over RX threshold and RX DMA level
        for (int t = 0; t < D; t++) begin
            wr(1, t); wr(6, t); wr(4, 1); wr(2, 5'b11000);
            enable = 1; tick();
            for (int i = 0; i <= D; i++) begin rx_push = 1; tick(); end
            wr(3, 1);
            chk("R5 clear all rx ovf", int'(raw_irq[3]), 0);
            enable = 0; tick();
        end

        // R6/R10 sweep over TX threshold and TX DMA level
        for (int t = 0; t < D; t++) begin
            wr(0, t); wr(5, t); wr(4, 2); wr(2, 5'b00011);
            enable = 1; tick();
            for (int i = 0; i <= D; i++) begin tx_push = 1; engine_busy = (i % 3 == 0); tick(); end
            for (int i = 0; i <= D; i++) begin tx_pop = 1; tick(); end
            engine_busy = 0;
            wr(3, 8);
            chk("R5 clear tx ovf", int'(raw_irq[1]), 0);
            enable = 0; tick();
        end

        // R5 individual clear bits
        enable = 1; tick();
        set_all_flags();
        chk("R5 all set", int'(raw_irq[3:1]), 7);
        wr(3, 4);
        chk("R5 bit2 clears rx ovf only", int'(raw_irq[3:1]), 3'b011);
        wr(3, 2);
        chk("R5 bit1 clears rx unf only", int'(raw_irq[3:1]), 3'b001);
        wr(3, 8);
        chk("R5 bit3 clears tx ovf", int'(raw_irq[3:1]), 0);
        // set beats clear in the same cycle
        enable = 0; tick(); enable = 1; tick();
        rx_pop = 1; wr(3, 1);
        chk("R5 set wins over clear", int'(raw_irq[2]), 1);
        wr(3, 1);

        // R9 mask sweep with all flags raised
        set_all_flags();
        for (int m = 0; m < 32; m++) begin
            wr(2, m);
            chk("R9 irq vs mask", int'(irq), ((int'(raw_irq) & m) != 0) ? 1 : 0);
        end
        wr(3, 1);

        // R11 flush and ignore while disabled
        for (int i = 0; i < 5; i++) begin tx_push = 1; rx_push = 1; tick(); end
        enable = 0; tick();
        chk("R11 flush tx", int'(tx_level), 0);
        chk("R11 flush rx", int'(rx_level), 0);
        rx_pop = 1; tx_push = 1; tick();
        chk("R11 no underflow while off", int'(raw_irq[2]), 0);
        chk("R11 no push while off", int'(tx_level), 0);

        // R12 threshold lock while enabled
        wr(1, 10);
        enable = 1; tick();
        wr(1, 2);
        wr(7, 31);
        for (int i = 0; i < 5; i++) begin rx_push = 1; tick(); end
        chk("R12 locked rx threshold", int'(raw_irq[4]), 0);
        for (int i = 0; i < 6; i++) begin rx_push = 1; tick(); end
        chk("R12 old threshold still used", int'(raw_irq[4]), 1);
        wr(2, 5'b10000);
        chk("R12 mask write while enabled", int'(irq), 1);

        // mixed pseudo-random phase
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = int'($urandom);
            tx_push = r[0]; tx_pop = r[1]; rx_push = r[2]; rx_pop = r[3];
            engine_busy = r[4];
            if (r[10:5] == 0) enable = ~enable;
            if (r[13:11] == 0) begin
                wr_en = 1; wr_addr = r[16:14]; wr_data = r[21:17];
            end
            if (k % 1000 < 500) begin tx_pop = tx_pop & r[22]; rx_pop = rx_pop & r[23]; end
            tick();
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule